// File: doc/BRIEF.md
# Serial Interrupt Slot Agent

This block is the peripheral end of a single-wire, open-drain serial interrupt line that is sampled on a bus clock. It watches the line for a long low pulse, the Start frame. It then counts three-clock data frames, using the moment the line returns high as its time reference. When the frame numbered by `slot_sel` comes round, the agent reports the level of its local active-low interrupt. It pulls the line low in the first clock of that frame. In the second clock it drives the line high to recover it, but only if it pulled it low in the first. It releases the line in the third clock.

The host ends each round with a Stop frame: a low pulse of two or three clocks. The agent measures its width to learn the next operating mode. A two-clock Stop selects quiet mode. In quiet mode a device with a pending interrupt may start a round itself: while the line is idle, the agent pulls it low for a single clock and then lets the host stretch that pulse into a full Start frame. A three-clock Stop selects continuous mode, in which only the host starts rounds.

The pad is modelled as two enables, `drive_lo` and `drive_hi`. The line is released when neither is set. A pull-up outside the block keeps an undriven line high.

Top module: `sirq_slot_agent`

## Requirements
- R1: While reset is held, and in the first cycle after it, both `drive_lo` and `drive_hi` are 0. The mode after reset is continuous.
- R2: A low period on `line_in` of at least START_MIN clocks (default 4), seen while idle and ended by a high sample, is a Start frame. The clock after that high sample is phase 0 of slot 0. A shorter low period is ignored and produces no slot drive.
- R3: In phase 0 (sample) of the slot equal to `slot_sel`, `drive_lo` is 1 if `irq_n` is 0. If `irq_n` is 1, the line is left undriven.
- R4: In phase 1 (recovery), `drive_hi` is 1 exactly when `drive_lo` was 1 in the clock before. Otherwise both enables are 0.
- R5: In phase 2 (turn-around) of every slot, both enables are 0.
- R6: Slots are numbered 0 to NUM_SLOTS-1 (default 21), each three clocks long. In slots other than `slot_sel`, and in every slot when `slot_sel` is NUM_SLOTS or more, both enables stay 0.
- R7: After the last slot, the low run that follows is a Stop frame, ended by a high sample. A width of 2 clocks sets quiet mode and a width of 3 sets continuous mode. Any other width leaves the mode unchanged.
- R8: In quiet mode, with the line idle and high and `irq_n` 0, the agent raises `drive_lo` for exactly one clock, one clock later, to request a Start frame.
- R9: In continuous mode the agent never drives the line outside its own slot.
- R10: `drive_lo` and `drive_hi` are never 1 in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level of the shared serial interrupt line |
| slot_sel | input | SLOT_W (5) | Slot number assigned to this agent |
| irq_n | input | 1 | Local interrupt, active low |
| drive_lo | output | 1 | Pull the line low in this clock |
| drive_hi | output | 1 | Drive the line high in this clock |

## Verification
A table of rounds changes the assigned slot, the interrupt level and the Stop width. Each round walks every phase of every slot. A pending interrupt in slots 3 and 12 shows the agent driving in its own slot and staying quiet in the others. Slots 0 and 20 test the first and last slot. Slot 25 tests an out-of-range assignment, and an idle interrupt shows that no drive occurs when `irq_n` is high. After each Stop, the bench checks whether a request pulse follows, which shows whether a two-clock or a three-clock Stop was decoded. Directed cases follow: a three-clock low that must be ignored, a Start of exactly four clocks, a reset in the middle of a frame, and the absence of any request in the continuous mode that follows reset.

// File: rtl/sia_pkg.sv
package sia_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_START = 3'd2,
    ST_FRAME = 3'd3,
    ST_STOP  = 3'd4
  } sia_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } sia_phase_e;

  // Low run long enough to count as a Start frame.
  function automatic logic start_valid(input int unsigned lows, input int unsigned min_lows);
    return lows >= min_lows;
  endfunction

  // Stop width decode: bit 1 = width is legal, bit 0 = next mode is quiet.
  function automatic logic [1:0] stop_decode(input int unsigned lows);
    case (lows)
      2:       return 2'b11;
      3:       return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/sia_seq.sv
module sia_seq
  import sia_pkg::*;
#(
  parameter int NUM_SLOTS = 21,
  parameter int START_MIN = 4,
  parameter int CNT_W     = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              quiet,
  input  logic              irq_n,
  output sia_state_e        state,
  output sia_phase_e        phase,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_start,
  output logic              stop_done,
  output logic [CNT_W-1:0]  stop_lows
);

  localparam logic [SLOT_W-1:0] LAST_SLOT   = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [CNT_W-1:0]  START_MIN_C = CNT_W'(START_MIN);
  localparam logic [CNT_W-1:0]  CNT_MAX     = '1;

  logic [CNT_W-1:0]  low_cnt, low_cnt_d, low_inc;
  sia_state_e        state_d;
  sia_phase_e        phase_d;
  logic [SLOT_W-1:0] slot_d;
  logic              last_turn;

  assign low_inc     = (low_cnt == CNT_MAX) ? low_cnt : low_cnt + 1'b1;
  assign frame_start = (state == ST_START) && line_in && start_valid(int'(low_cnt), START_MIN);
  assign stop_done   = (state == ST_STOP) && line_in && (low_cnt != '0);
  assign stop_lows   = low_cnt;
  assign last_turn   = (state == ST_FRAME) && (phase == PH_TURN) && (slot == LAST_SLOT);

  always_comb begin
    state_d   = state;
    phase_d   = phase;
    slot_d    = slot;
    low_cnt_d = low_cnt;
    case (state)
      ST_IDLE: begin
        if (!line_in) begin
          state_d   = ST_START;
          low_cnt_d = CNT_W'(1);
        end else if (quiet && !irq_n) begin
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        state_d   = ST_START;
        low_cnt_d = CNT_W'(1);
      end
      ST_START: begin
        if (!line_in) begin
          low_cnt_d = low_inc;
        end else if (frame_start) begin
          state_d = ST_FRAME;
          phase_d = PH_SAMPLE;
          slot_d  = '0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_FRAME: begin
        case (phase)
          PH_SAMPLE:  phase_d = PH_RECOVER;
          PH_RECOVER: phase_d = PH_TURN;
          default: begin
            phase_d = PH_SAMPLE;
            if (last_turn) begin
              state_d   = ST_STOP;
              low_cnt_d = '0;
            end else begin
              slot_d = slot + 1'b1;
            end
          end
        endcase
      end
      ST_STOP: begin
        if (!line_in)       low_cnt_d = low_inc;
        else if (stop_done) state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_SAMPLE;
      slot    <= '0;
      low_cnt <= '0;
    end else begin
      state   <= state_d;
      phase   <= phase_d;
      slot    <= slot_d;
      low_cnt <= low_cnt_d;
    end
  end

  // R2: frames begin only after a long enough low run
  a_r2_start_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FRAME && $past(state) != ST_FRAME) |-> ($past(low_cnt) >= START_MIN_C));

  // R6: slot index stays inside the frame table
  a_r6_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FRAME) |-> (slot <= LAST_SLOT));

  // R8: the request lasts a single clock
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ) |=> (state == ST_START));

  // R9: a request is only raised from quiet mode
  a_r9_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ) |-> $past(quiet));

endmodule

// File: rtl/sia_mode.sv
module sia_mode
  import sia_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_done,
  input  logic [CNT_W-1:0] stop_lows,
  output logic             quiet
);

  logic [1:0] dec;
  assign dec = stop_decode(int'(stop_lows));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 quiet <= 1'b0;
    else if (stop_done && dec[1]) quiet <= dec[0];
  end

  // R7: stop width picks the next mode
  a_r7_two_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && stop_lows == CNT_W'(2)) |=> quiet);
  a_r7_three_cont: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && stop_lows == CNT_W'(3)) |=> !quiet);

endmodule

// File: rtl/sia_drive.sv
module sia_drive
  import sia_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sia_state_e        state,
  input  sia_phase_e        phase,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              irq_n,
  output logic              drive_lo,
  output logic              drive_hi
);

  logic own_slot, sample_pull, drove_lo;

  assign own_slot    = (slot == slot_sel);
  assign sample_pull = (state == ST_FRAME) && (phase == PH_SAMPLE) && own_slot && !irq_n;
  assign drive_lo    = sample_pull || (state == ST_REQ);
  assign drive_hi    = (state == ST_FRAME) && (phase == PH_RECOVER) && drove_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drove_lo <= 1'b0;
    else        drove_lo <= sample_pull;
  end

  // R10: never both enables
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_lo && drive_hi));

  // R4: a high drive always follows a low drive
  a_r4_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    drive_hi |-> $past(drive_lo));

  // R5: turn-around is always released
  a_r5_turn_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FRAME && phase == PH_TURN) |-> (!drive_lo && !drive_hi));

endmodule

// File: rtl/sirq_slot_agent.sv
module sirq_slot_agent
  import sia_pkg::*;
#(
  parameter int NUM_SLOTS = 21,
  parameter int START_MIN = 4,
  parameter int CNT_W     = 4,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              irq_n,
  output logic              drive_lo,
  output logic              drive_hi
);

  sia_state_e        state;
  sia_phase_e        phase;
  logic [SLOT_W-1:0] slot;
  logic              frame_start, stop_done, quiet;
  logic [CNT_W-1:0]  stop_lows;

  sia_seq #(
    .NUM_SLOTS(NUM_SLOTS), .START_MIN(START_MIN), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .quiet(quiet), .irq_n(irq_n),
    .state(state), .phase(phase), .slot(slot), .frame_start(frame_start),
    .stop_done(stop_done), .stop_lows(stop_lows)
  );

  sia_mode #(.CNT_W(CNT_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .stop_done(stop_done), .stop_lows(stop_lows), .quiet(quiet)
  );

  sia_drive #(.SLOT_W(SLOT_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .state(state), .phase(phase), .slot(slot),
    .slot_sel(slot_sel), .irq_n(irq_n), .drive_lo(drive_lo), .drive_hi(drive_hi)
  );

  // R2: slot 0 sample phase follows a recognised start
  a_r2_slot0_first: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (state == ST_FRAME && phase == PH_SAMPLE && slot == '0));

  // R9: in continuous mode the idle line is never pulled
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && state == ST_IDLE) |-> !drive_lo);

endmodule

// File: tb/sirq_slot_agent_test.sv
module sirq_slot_agent_test;

  localparam int NUM_SLOTS = 21;
  localparam int SLOT_W    = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_lo = 1'b0;
  logic [SLOT_W-1:0] slot_sel = '0;
  logic              irq_n = 1'b1;
  logic              drive_lo, drive_hi, line_in;
  int                errs = 0;
  int                checks = 0;

  assign line_in = ~(host_lo | drive_lo);

  always #4 clk = ~clk;

  sirq_slot_agent uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .slot_sel(slot_sel),
    .irq_n(irq_n), .drive_lo(drive_lo), .drive_hi(drive_hi)
  );

  // {slot_sel, irq_n, stop width}
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    {5'd3,  1'b0, 3'd2},
    {5'd0,  1'b0, 3'd3},
    {5'd20, 1'b0, 3'd2},
    {5'd7,  1'b1, 3'd2},
    {5'd25, 1'b0, 3'd3},
    {5'd12, 1'b0, 3'd3}
  };

  task automatic step(input logic h);
    @(negedge clk);
    host_lo = h;
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_round(input int sel, input logic irq, input int w);
    slot_sel = SLOT_W'(sel);
    irq_n    = irq;
    for (int i = 0; i < 5; i++) step(1'b1);
    step(1'b0);
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < 3; p++) begin
        bit mine;
        step(1'b0);
        mine = (s == sel) && !irq;
        if (p == 0) chk("R3 sample drive_lo", drive_lo, int'(mine));
        if (p == 1) chk("R4 recovery drive_hi", drive_hi, int'(mine));
        if (p == 2) chk("R5 turnaround release", int'(drive_lo | drive_hi), 0);
        if (s != sel) chk("R6 foreign slot silent", int'(drive_lo | drive_hi), 0);
        chk("R10 exclusive", int'(drive_lo & drive_hi), 0);
      end
    end
    for (int i = 0; i < w; i++) step(1'b1);
    step(1'b0);
    step(1'b0);
    step(1'b0);
    chk("R7/R8/R9 request after stop", drive_lo, int'((w == 2) && !irq));
    step(1'b0);
    chk("R8 request one clock", drive_lo, 0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    irq_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset drive_lo", drive_lo, 0);
    chk("R1 reset drive_hi", drive_hi, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1'b0);
      chk("R1/R9 continuous after reset", drive_lo, 0);
    end

    for (int v = 0; v < NV; v++) begin
      run_round(int'(VEC[v][8:4]), VEC[v][3], int'(VEC[v][2:0]));
    end

    // R2: a three-clock low run is not a start
    slot_sel = '0;
    irq_n    = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1);
    step(1'b0);
    for (int i = 0; i < 3; i++) begin
      step(1'b0);
      chk("R2 short low ignored", drive_lo, 0);
    end

    // R2: exactly four low clocks starts slot 0
    for (int i = 0; i < 4; i++) step(1'b1);
    step(1'b0);
    step(1'b0);
    chk("R2 min start slot0 sample", drive_lo, 1);
    step(1'b0);
    chk("R4 min start slot0 recovery", drive_hi, 1);

    // R1: reset in mid-frame releases the line
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset mid-frame drive_lo", drive_lo, 0);
    chk("R1 reset mid-frame drive_hi", drive_hi, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0);
    step(1'b0);
    chk("R9 no request after mid reset", drive_lo, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule